// File: doc/BRIEF.md
# Watchdog Timer with Prescaler and Status Flags

This block is the watchdog of a small microcontroller. It counts ticks from one of two sources. The first is a pulse from a dedicated oscillator, already brought into the core clock domain. The second is the core clock divided by four. A fixed eight-stage binary divider gives the basic expiry of 256 ticks. A selectable prescaler multiplies that by a power of two, from 1 to 128. When the count expires during normal running, the block raises a one-cycle reset request and sets the time-out flag. When the core is halted, the same expiry raises a one-cycle wake-up request instead.

Software restarts the count with a two-step clear. It first strobes the arming command and later strobes the firing command. The completed sequence restarts the count, sets the time-out flag and clears the power-down flag. Entering the halt state also restarts the count, and it sets the power-down flag and clears the time-out flag. A configuration enable, when low, parks the counter and the clock divider at zero.

Top module: `watchdog_core`

## Requirements
- R1: After reset, `toFlag`, `pdFlag`, `rstReq` and `wakeReq` are all 0.
- R2: With `preSel` = p, an expiry occurs on the 256·2^p-th counted tick after the count restarts. The count then restarts from zero by itself.
- R3: With `srcSel` = 0, a clock cycle counts as a tick when `oscTick` is 1. With `srcSel` = 1, every fourth clock cycle counts as a tick (the 4th, 8th, … cycle after enabling), and `oscTick` is ignored.
- R4: An expiry while `inHalt` = 0 drives `rstReq` high for exactly one cycle, in the cycle after the final tick, and sets `toFlag` to 1 in that same cycle.
- R5: An expiry while `inHalt` = 1 drives `wakeReq` high for one cycle and leaves `rstReq` low. `toFlag` and `pdFlag` keep their values.
- R6: A `clrSecond` strobe that arrives after a `clrFirst` strobe in an earlier cycle completes a clear. The count restarts from zero, `toFlag` becomes 1, `pdFlag` becomes 0, and the arming is used up.
- R7: A `clrSecond` strobe with no earlier `clrFirst` since the last completed clear has no effect. The count and both flags are unchanged.
- R8: A `haltEnter` strobe restarts the count from zero, sets `pdFlag` to 1 and clears `toFlag` to 0.
- R9: While `wdtEn` = 0, the counter and the divide-by-four stage stay at zero and no request is raised. Counting starts afresh when `wdtEn` returns to 1.
- R10: When requests arrive in the same cycle, they take priority in this order: `haltEnter` first, then a completing clear, then counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wdtEn | input | 1 | Configuration enable; 0 holds the count at zero |
| srcSel | input | 1 | Tick source: 0 = oscillator pulse, 1 = core clock / 4 |
| oscTick | input | 1 | Synchronised one-cycle pulse from the dedicated oscillator |
| preSel | input | 3 | Prescaler exponent p; ratio 2^p |
| clrFirst | input | 1 | Clear arming strobe |
| clrSecond | input | 1 | Clear firing strobe |
| haltEnter | input | 1 | Strobe marking entry into halt |
| inHalt | input | 1 | Level, 1 while the core is halted |
| rstReq | output | 1 | One-cycle chip reset request |
| wakeReq | output | 1 | One-cycle wake-up request |
| toFlag | output | 1 | Time-out status flag |
| pdFlag | output | 1 | Power-down status flag |

## Verification
The expiry is measured as an exact cycle number for several conditions: prescaler ratios 1 and 2, the oscillator path held at every cycle, the oscillator path held silent, and the divided clock path. A one-cycle error in the divider chain or in the prescaler decode therefore shows up as a miscompare. The count is run while running and while halted, so a swap between reset and wake-up is caught, along with the flag state that comes with each. Clear sequences are tried complete and incomplete (a firing strobe with no arming), and once colliding with a halt entry. This separates a correct arming handshake and priority from a single-strobe clear or a reversed priority. A long stretch with the enable low, while ticks keep arriving, shows whether the counter is really held.

// File: rtl/watchdog_pkg.sv
package watchdog_pkg;

  // Strobes sent from the control to the datapath each cycle
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic toSet;
    logic toClr;
    logic pdSet;
    logic pdClr;
    logic rstFire;
    logic wakeFire;
  } wdtStrobes_t;

endpackage

// File: rtl/watchdog_datapath.sv
module watchdog_datapath
  import watchdog_pkg::*;
#(
  parameter int DIV_STAGES = 8,
  parameter int PRE_SEL_W  = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  wdtStrobes_t          strobes,
  input  logic [PRE_SEL_W-1:0] preSel,
  output logic                 atLimit,
  output logic                 rstReq,
  output logic                 wakeReq,
  output logic                 toFlag,
  output logic                 pdFlag
);

  localparam int PRE_MAX = (1 << PRE_SEL_W) - 1;
  localparam int CNT_W   = DIV_STAGES + PRE_MAX;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   limitVal;

  // Period in ticks = 2^(DIV_STAGES + preSel)
  assign limitVal = (CNT_W+1)'(1) << (DIV_STAGES + int'(preSel));
  assign atLimit  = ({1'b0, cnt} == (limitVal - 1'b1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobes.cntClr) begin
      cnt <= '0;
    end else if (strobes.cntInc) begin
      cnt <= atLimit ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toFlag <= 1'b0;
      pdFlag <= 1'b0;
    end else begin
      if (strobes.toClr)      toFlag <= 1'b0;
      else if (strobes.toSet) toFlag <= 1'b1;
      if (strobes.pdClr)      pdFlag <= 1'b0;
      else if (strobes.pdSet) pdFlag <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstReq  <= 1'b0;
      wakeReq <= 1'b0;
    end else begin
      rstReq  <= strobes.rstFire;
      wakeReq <= strobes.wakeFire;
    end
  end

endmodule

// File: rtl/watchdog_ctrl.sv
module watchdog_ctrl
  import watchdog_pkg::*;
#(
  parameter int SRC_DIV_W = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wdtEn,
  input  logic        srcSel,
  input  logic        oscTick,
  input  logic        clrFirst,
  input  logic        clrSecond,
  input  logic        haltEnter,
  input  logic        inHalt,
  input  logic        atLimit,
  output wdtStrobes_t strobes
);

  logic divWrap;
  logic tick;
  logic armed;
  logic clrDone;

  generate
    if (SRC_DIV_W > 0) begin : gDiv
      logic [SRC_DIV_W-1:0] divCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       divCnt <= '0;
        else if (!wdtEn) divCnt <= '0;
        else             divCnt <= divCnt + 1'b1;
      end
      assign divWrap = &divCnt;
    end else begin : gNoDiv
      assign divWrap = 1'b1;
    end
  endgenerate

  assign tick    = wdtEn && (srcSel ? divWrap : oscTick);
  assign clrDone = clrSecond && armed;

  // Arming of the two-step clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         armed <= 1'b0;
    else if (clrDone)  armed <= 1'b0;
    else if (clrFirst) armed <= 1'b1;
  end

  always_comb begin
    strobes = '0;
    if (haltEnter) begin
      strobes.cntClr = 1'b1;
      strobes.pdSet  = 1'b1;
      strobes.toClr  = 1'b1;
    end else if (clrDone) begin
      strobes.cntClr = 1'b1;
      strobes.toSet  = 1'b1;
      strobes.pdClr  = 1'b1;
    end else if (!wdtEn) begin
      strobes.cntClr = 1'b1;
    end else if (tick) begin
      strobes.cntInc = 1'b1;
      if (atLimit) begin
        if (inHalt) begin
          strobes.wakeFire = 1'b1;
        end else begin
          strobes.rstFire = 1'b1;
          strobes.toSet   = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/watchdog_core.sv
module watchdog_core
  import watchdog_pkg::*;
#(
  parameter int DIV_STAGES = 8,
  parameter int PRE_SEL_W  = 3,
  parameter int SRC_DIV_W  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wdtEn,
  input  logic                 srcSel,
  input  logic                 oscTick,
  input  logic [PRE_SEL_W-1:0] preSel,
  input  logic                 clrFirst,
  input  logic                 clrSecond,
  input  logic                 haltEnter,
  input  logic                 inHalt,
  output logic                 rstReq,
  output logic                 wakeReq,
  output logic                 toFlag,
  output logic                 pdFlag
);

  wdtStrobes_t strobes;
  logic        atLimit;

  watchdog_ctrl #(.SRC_DIV_W(SRC_DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wdtEn(wdtEn), .srcSel(srcSel),
    .oscTick(oscTick), .clrFirst(clrFirst), .clrSecond(clrSecond),
    .haltEnter(haltEnter), .inHalt(inHalt), .atLimit(atLimit),
    .strobes(strobes)
  );

  watchdog_datapath #(.DIV_STAGES(DIV_STAGES), .PRE_SEL_W(PRE_SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .preSel(preSel),
    .atLimit(atLimit), .rstReq(rstReq), .wakeReq(wakeReq),
    .toFlag(toFlag), .pdFlag(pdFlag)
  );

endmodule

// File: rtl/watchdog_checker.sv
module watchdog_checker (
  input logic clk,
  input logic rstN,
  input logic wdtEn,
  input logic haltEnter,
  input logic inHalt,
  input logic rstReq,
  input logic wakeReq,
  input logic toFlag,
  input logic pdFlag
);

  assert_rst_sets_to_R4: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> toFlag);

  assert_rst_one_cycle_R4: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);

  assert_wake_only_halted_R5: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> $past(inHalt));

  assert_req_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(rstReq && wakeReq));

  assert_halt_flags_R8: assert property (@(posedge clk) disable iff (!rstN)
    haltEnter |=> (pdFlag && !toFlag));

  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wdtEn) |-> (!rstReq && !wakeReq));

endmodule

bind watchdog_core watchdog_checker u_wdtChk (
  .clk(clk), .rstN(rstN), .wdtEn(wdtEn), .haltEnter(haltEnter),
  .inHalt(inHalt), .rstReq(rstReq), .wakeReq(wakeReq),
  .toFlag(toFlag), .pdFlag(pdFlag)
);

// File: tb/tb_watchdog_core.sv
`timescale 1ns/1ps
module tb_watchdog_core;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wdtEn = 1'b0, srcSel = 1'b0, oscTick = 1'b0;
  logic [2:0] preSel = 3'd0;
  logic       clrFirst = 1'b0, clrSecond = 1'b0, haltEnter = 1'b0, inHalt = 1'b0;
  logic       rstReq, wakeReq, toFlag, pdFlag;

  int vectors = 0;
  int miscompares = 0;
  int edgeNo = 0;
  bit done = 1'b0;

  // Scoreboard of expected request pulses
  int expEdge[$];
  int expWake[$];
  string expTag[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) edgeNo <= edgeNo + 1;

  watchdog_core dut (
    .clk(clk), .rstN(rstN), .wdtEn(wdtEn), .srcSel(srcSel), .oscTick(oscTick),
    .preSel(preSel), .clrFirst(clrFirst), .clrSecond(clrSecond),
    .haltEnter(haltEnter), .inHalt(inHalt), .rstReq(rstReq), .wakeReq(wakeReq),
    .toFlag(toFlag), .pdFlag(pdFlag)
  );

  task automatic checkVal(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expectPulse(input int atEdge, input int wake, input string tag);
    expEdge.push_back(atEdge);
    expWake.push_back(wake);
    expTag.push_back(tag);
  endtask

  task automatic stepN(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops one expectation per observed request pulse
  always @(negedge clk) begin
    if (rstN && !done && (rstReq || wakeReq)) begin
      if (expEdge.size() == 0) begin
        vectors++;
        miscompares++;
        $display("FAIL R9 unexpected request: actual edge %0d expected none", edgeNo);
      end else begin
        int e; int w; string t;
        e = expEdge.pop_front();
        w = expWake.pop_front();
        t = expTag.pop_front();
        checkVal({t, " edge"}, edgeNo, e);
        checkVal({t, " kind(wake=1)"}, int'(wakeReq), w);
        checkVal({t, " other request low"}, int'(rstReq && wakeReq), 0);
      end
    end
  end

  task automatic finishRun();
    done = 1'b1;
    checkVal("R2 all expected pulses seen", expEdge.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    vectors++;
    miscompares++;
    $display("FAIL watchdog expired: actual running expected finished");
    finishRun();
  end

  initial begin
    int s;
    stepN(3);
    // R1 reset state
    checkVal("R1 toFlag", int'(toFlag), 0);
    checkVal("R1 pdFlag", int'(pdFlag), 0);
    checkVal("R1 rstReq", int'(rstReq), 0);
    checkVal("R1 wakeReq", int'(wakeReq), 0);
    rstN = 1'b1;
    stepN(2);

    // R2 R4: basic time-out, oscillator every cycle, ratio 1
    oscTick = 1'b1; preSel = 3'd0; wdtEn = 1'b1; s = edgeNo;
    expectPulse(s + 256, 0, "R2 R4 ratio1");
    stepN(257);
    checkVal("R4 toFlag after reset request", int'(toFlag), 1);
    checkVal("R4 pdFlag untouched", int'(pdFlag), 0);
    wdtEn = 1'b0; stepN(2);

    // R8 R5: halt entry then wake-up on expiry
    wdtEn = 1'b1; inHalt = 1'b1; haltEnter = 1'b1; s = edgeNo;
    expectPulse(s + 1 + 256, 1, "R5 halted wake");
    stepN(1); haltEnter = 1'b0;
    checkVal("R8 pdFlag after halt", int'(pdFlag), 1);
    checkVal("R8 toFlag after halt", int'(toFlag), 0);
    stepN(257);
    checkVal("R5 toFlag kept", int'(toFlag), 0);
    checkVal("R5 pdFlag kept", int'(pdFlag), 1);
    inHalt = 1'b0; wdtEn = 1'b0; stepN(2);

    // R7: lone second clear ignored
    wdtEn = 1'b1; s = edgeNo;
    expectPulse(s + 256, 0, "R7 count unaffected");
    stepN(50); clrSecond = 1'b1; stepN(1); clrSecond = 1'b0; stepN(1);
    checkVal("R7 toFlag unchanged", int'(toFlag), 0);
    checkVal("R7 pdFlag unchanged", int'(pdFlag), 1);
    stepN(256 - 52 + 1);
    wdtEn = 1'b0; stepN(2);

    // R6: complete clear sequence, ratio 2
    preSel = 3'd1; wdtEn = 1'b1; s = edgeNo;
    stepN(300); clrFirst = 1'b1;
    stepN(1); clrFirst = 1'b0; clrSecond = 1'b1;
    expectPulse(edgeNo + 1 + 512, 0, "R6 R2 ratio2 after clear");
    stepN(1); clrSecond = 1'b0;
    checkVal("R6 toFlag after clear", int'(toFlag), 1);
    checkVal("R6 pdFlag after clear", int'(pdFlag), 0);
    stepN(513);
    wdtEn = 1'b0; stepN(2);

    // R10: halt entry collides with completing clear
    preSel = 3'd0; wdtEn = 1'b1;
    stepN(100); clrFirst = 1'b1;
    stepN(1); clrFirst = 1'b0; clrSecond = 1'b1; haltEnter = 1'b1; inHalt = 1'b1;
    expectPulse(edgeNo + 1 + 256, 1, "R10 halt wins");
    stepN(1); clrSecond = 1'b0; haltEnter = 1'b0;
    checkVal("R10 pdFlag halt priority", int'(pdFlag), 1);
    checkVal("R10 toFlag halt priority", int'(toFlag), 0);
    stepN(257);
    inHalt = 1'b0; wdtEn = 1'b0;

    // R9: disabled for longer than a period, ticks present
    stepN(600);
    checkVal("R9 toFlag while disabled", int'(toFlag), 0);
    wdtEn = 1'b1; s = edgeNo;
    expectPulse(s + 256, 0, "R9 fresh start");
    stepN(257);
    wdtEn = 1'b0; stepN(2);

    // R3: silent oscillator, then divided clock source
    oscTick = 1'b0; srcSel = 1'b0; wdtEn = 1'b1; s = edgeNo;
    stepN(300);
    srcSel = 1'b1;
    expectPulse(s + 300 + 1024, 0, "R3 clock/4 source");
    stepN(1025);
    wdtEn = 1'b0; stepN(3);

    finishRun();
  end

endmodule